// File: doc/BRIEF.md
# Bidirectional I/O Port with Timer Pin Takeover

An 8-bit general-purpose I/O port sits behind a two-register bus: a data latch and a direction register. Each bit of the direction register makes its pin an output (1) or an input (0). Reads of the data address return, bit by bit, the synchronized pad level for input pins and the driver value for output pins. Writes always land in the latch. The latch reaches a pad only while that pad is an ordinary output.

The upper five pins can also be seized by a timer. Four compare channels each own one pin: pin 6, 5, 4 and 3. A channel owns its pin whenever its 2-bit mode field is nonzero. The pin-3 channel gives way when the capture-select input chooses capture for that pin. A fifth channel, the mask channel, can drive any mix of pins 3 to 7 through a 5-bit mask. It takes precedence over everything else on those pins. A seized pin is always an output, whatever its direction bit says. Pad sensing is always live, and the synchronized levels of all eight pads are exported for capture and pulse counting logic.

Top module: `gpio_tmr_port`

## Requirements
- R1: After reset, the data latch and the direction register read 0x00 and every pad_oe bit is 0.
- R2: With no timer claim, pad_oe[i] equals direction bit i. The direction register is written and read at bus_addr=1. A write becomes visible on the cycle after the write edge.
- R3: A read at bus_addr=0 returns pad_out[i] for pins with pad_oe[i]=1. For other pins it returns pad_in[i] as sampled two rising edges earlier.
- R4: A write at bus_addr=0 always updates the latch. The latch appears on pad_out[i] only for pins that are outputs with no timer claim.
- R5: Pins 0 to 2 take pad_oe only from their direction bits. No timer input affects them.
- R6: A nonzero chN_mode (N = 6, 5, 4, 3 for pins 6, 5, 4, 3) forces that pin's pad_oe to 1 and drives ch_level[N-3] onto it. Latch writes then leave the pad unchanged.
- R7: oc1_mask[k]=1 forces pad_oe[k+3]=1 and drives oc1_level[k] onto pad k+3, for k = 0..4.
- R8: When the mask channel and a per-pin channel claim the same pin, the pad carries oc1_level.
- R9: cap4_sel=1 cancels the pin-3 channel's claim, so pin 3 follows its direction bit and the latch. The mask channel still acts on pin 3.
- R10: pin_sense equals pad_in delayed by two rising edges on every pin, including pins driven as outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data latch/pins, 1 = direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ch6_mode | input | 2 | Pin-6 compare channel mode, nonzero = owns pin |
| ch5_mode | input | 2 | Pin-5 compare channel mode |
| ch4_mode | input | 2 | Pin-4 compare channel mode |
| ch3_mode | input | 2 | Pin-3 compare channel mode |
| ch_level | input | 4 | Channel output levels, bit k for pin k+3 |
| cap4_sel | input | 1 | 1 = pin 3 used for capture |
| oc1_mask | input | 5 | Mask channel pin claims, bit k for pin k+3 |
| oc1_level | input | 5 | Mask channel levels, bit k for pin k+3 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pin_sense | output | 8 | Synchronized pad levels |

## Verification
A bus write to the data latch can fall in the same cycle that a compare channel claims the pin. The bench issues a latch write while ch5_mode is nonzero. It then judges the pad as showing the channel level, and the latch as holding the new value once the claim is released. The other pairing is the mask channel and a per-pin channel claiming one pin together. The bench holds both on pins 6 and 3 with opposite levels and expects the mask level on the pad.

// File: rtl/gpio_tmr_port.sv
module gpio_tmr_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] ch6_mode,
  input  logic [1:0] ch5_mode,
  input  logic [1:0] ch4_mode,
  input  logic [1:0] ch3_mode,
  input  logic [3:0] ch_level,
  input  logic       cap4_sel,
  input  logic [4:0] oc1_mask,
  input  logic [4:0] oc1_level,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic [7:0] pin_sense
);
  logic [7:0] dat_q, dir_q, sync1_q, sync2_q;
  logic [7:0] ch_own, ch_val, m_own, m_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q   <= '0;
      dir_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      if (bus_sel && bus_wr) begin
        if (bus_addr) dir_q <= bus_wdata;
        else          dat_q <= bus_wdata;
      end
    end
  end

  assign ch_own = {1'b0, |ch6_mode, |ch5_mode, |ch4_mode, (|ch3_mode) & ~cap4_sel, 3'b000};
  assign ch_val = {1'b0, ch_level, 3'b000};
  assign m_own  = {oc1_mask, 3'b000};
  assign m_val  = {oc1_level, 3'b000};

  assign pad_oe  = dir_q | ch_own | m_own;
  assign pad_out = (m_own & m_val) | (~m_own & ch_own & ch_val) | (~m_own & ~ch_own & dat_q);
  assign pin_sense = sync2_q;
  assign bus_rdata = bus_addr ? dir_q : ((pad_oe & pad_out) | (~pad_oe & sync2_q));
endmodule

// File: rtl/gpio_tmr_port_chk.sv
module gpio_tmr_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [1:0] ch6_mode,
  input logic [1:0] ch3_mode,
  input logic [3:0] ch_level,
  input logic       cap4_sel,
  input logic [4:0] oc1_mask,
  input logic [4:0] oc1_level,
  input logic [7:0] pad_in,
  input logic [7:0] pad_out,
  input logic [7:0] pad_oe,
  input logic [7:0] pin_sense
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  p_low_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr) |=> pad_oe[2:0] == $past(bus_wdata[2:0]));

  p_ch6_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch6_mode != 2'b00 && !oc1_mask[3]) |-> (pad_oe[6] && pad_out[6] == ch_level[3]));

  p_mask_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oc1_mask[4] |-> (pad_oe[7] && pad_out[7] == oc1_level[4]));

  p_mask_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oc1_mask[0] && ch3_mode != 2'b00 && !cap4_sel) |-> pad_out[3] == oc1_level[0]);

  p_sense_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> pin_sense == $past(pad_in, 2));
endmodule

bind gpio_tmr_port gpio_tmr_port_chk chk_i (.*);

// File: tb/gpio_tmr_port_tb_top.sv
module gpio_tmr_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] ch6_mode = 0, ch5_mode = 0, ch4_mode = 0, ch3_mode = 0;
  logic [3:0] ch_level = 0;
  logic cap4_sel = 0;
  logic [4:0] oc1_mask = 0, oc1_level = 0;
  logic [7:0] pad_in = 0, pad_out, pad_oe, pin_sense;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_tmr_port dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_sel = 1;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic clear_timer();
    @(negedge clk);
    ch6_mode = 0; ch5_mode = 0; ch4_mode = 0; ch3_mode = 0;
    ch_level = 0; cap4_sel = 0; oc1_mask = 0; oc1_level = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v); chk("R1 dir", v, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    pad_in = 8'h00;
    rd(1'b0, v); chk("R1 data", v, 8'h00);
  endtask

  task automatic t_gpio();
    logic [7:0] v;
    wr(1'b1, 8'h0F);
    rd(1'b1, v); chk("R2 dir read", v, 8'h0F);
    chk("R2 oe", pad_oe, 8'h0F);
    wr(1'b0, 8'hA5);
    chk("R4 out", pad_out, 8'hA5);
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    rd(1'b0, v); chk("R3 mixed read", v, 8'h35);
  endtask

  task automatic t_low_pins();
    wr(1'b1, 8'h00);
    @(negedge clk);
    ch6_mode = 2'b11; ch5_mode = 2'b01; ch4_mode = 2'b10; ch3_mode = 2'b01;
    oc1_mask = 5'h1F; ch_level = 4'hF; oc1_level = 5'h1F;
    #1 chk("R5 low oe", {5'b0, pad_oe[2:0]}, 8'h00);
    chk("R7 mask all oe", pad_oe, 8'hF8);
    clear_timer();
  endtask

  task automatic t_channel();
    logic [7:0] v;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    @(negedge clk); ch5_mode = 2'b10; ch_level = 4'b0100;
    #1 chk("R6 oe", pad_oe, 8'h20);
    chk("R6 out", pad_out & 8'h20, 8'h20);
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00;
    @(negedge clk); bus_sel = 0; bus_wr = 0; ch_level = 4'b0000;
    wr(1'b0, 8'h20);
    chk("R6 write ignored", pad_out & 8'h20, 8'h00);
    @(negedge clk); ch5_mode = 0;
    wr(1'b1, 8'h20);
    rd(1'b0, v); chk("R4 latch held", v & 8'h20, 8'h20);
  endtask

  task automatic t_mask();
    wr(1'b1, 8'h00);
    @(negedge clk);
    ch6_mode = 2'b01; ch3_mode = 2'b11; ch_level = 4'b0000;
    oc1_mask = 5'b01001; oc1_level = 5'b01001;
    #1 chk("R8 mask wins", pad_out & 8'h48, 8'h48);
    @(negedge clk); oc1_mask = 5'b10000; oc1_level = 5'b00000;
    #1 chk("R7 pin7", {pad_oe[7], pad_out[7]}, 8'h02);
    clear_timer();
  endtask

  task automatic t_cap4();
    wr(1'b0, 8'h08);
    wr(1'b1, 8'h00);
    @(negedge clk); ch3_mode = 2'b01; ch_level = 4'b0000; cap4_sel = 1;
    #1 chk("R9 no force", {7'b0, pad_oe[3]}, 8'h00);
    wr(1'b1, 8'h08);
    chk("R9 latch drives", {7'b0, pad_out[3]}, 8'h01);
    @(negedge clk); oc1_mask = 5'b00001; oc1_level = 0;
    #1 chk("R9 mask still acts", {7'b0, pad_out[3]}, 8'h00);
    clear_timer();
  endtask

  task automatic t_sense();
    @(negedge clk); oc1_mask = 5'b10000; oc1_level = 5'b10000; pad_in = 8'h00;
    @(negedge clk); @(negedge clk);
    chk("R10 sense low", pin_sense, 8'h00);
    pad_in = 8'h81;
    @(negedge clk);
    chk("R10 one edge", pin_sense, 8'h00);
    @(negedge clk);
    chk("R10 driven pin sensed", pin_sense, 8'h81);
    clear_timer();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gpio();
    t_low_pins();
    t_channel();
    t_mask();
    t_cap4();
    t_sense();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule